// File: doc/BRIEF.md
# ADC Serial Frame Reader

This block is the host side of a link to a serial-output sampling ADC. A one-cycle `start` pulse opens a frame: the reader pulls the active-low chip select down, which makes the converter sample and start converting. After one half period it toggles a serial clock that it divides down from the system clock. It collects the bits the converter shifts out and keeps only the data field. When the frame closes it presents the sample, right-aligned in a 12-bit word, together with a one-cycle valid strobe.

A converter frame begins with two zeros, the first of them already on the line when chip select falls. The data bits follow, most significant first, and zeros fill the rest of a 16-clock frame. The reader can also run a shortened 14-clock frame that never clocks out the last two padding bits. It can capture on the falling or on the rising serial clock edge. If any non-data position that it captured reads one, it raises a framing-error flag next to the result. Resolution (12, 10 or 8 bits) is fixed at elaboration. Frame length, capture edge, clock divider and the quiet gap between frames are run-time inputs. The frame length and capture edge are latched when a frame is accepted.

Top module: `adc_frame_reader`

## Requirements
- R1: During and after reset, `cs_n` and `sclk` are 1, `busy` and `result_valid` are 0.
- R2: `sclk` is 1 whenever `cs_n` is 1. After `cs_n` falls, the first `sclk` falling edge comes one half period later.
- R3: Each `sclk` half period lasts `div_half` system clocks, with 0 treated as 1, so `cs_n` stays low for exactly 2·N·`div_half` system clocks in an N-clock frame.
- R4: A frame issues 16 `sclk` falling edges when `short_frame` was 0 at acceptance and 14 when it was 1. `cs_n` rises one half period after the last falling edge and never before it.
- R5: With `rise_sample`=0, frame position k (position 1 is the bit present at the `cs_n` fall, position k+1 is launched by falling edge k) is captured on falling edge k, for k = 1..N.
- R6: With `rise_sample`=1, positions 2..N are captured on rising edges 1..N-1. Position 1 is never captured.
- R7: Positions 3 to RES_BITS+2 are the data, MSB first. `result` holds them right-aligned, and its bits above RES_BITS are 0.
- R8: `frame_err` is 1 exactly when some captured position outside the data field read 1. The result is delivered either way.
- R9: `result_valid` is a single-cycle pulse in the cycle in which `cs_n` returns to 1. `result` and `frame_err` are valid in that cycle.
- R10: `start` is ignored while a frame runs, and until `quiet_cycles` system clocks have passed in idle since the last frame ended or since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one frame |
| short_frame | input | 1 | 1 selects a 14-clock frame, 0 a 16-clock frame |
| rise_sample | input | 1 | 1 captures on rising `sclk` edges, 0 on falling |
| div_half | input | DIV_W | System clocks per `sclk` half period |
| quiet_cycles | input | QUIET_W | Minimum idle system clocks between frames |
| sdata_in | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame in progress |
| result | output | 12 | Sample, right-aligned |
| result_valid | output | 1 | One-cycle strobe for `result` |
| frame_err | output | 1 | Non-data position read 1 |

## Verification
The bench plants a single one at chosen non-data positions. A one at position 1 must raise the flag under falling-edge capture and must be missed under rising-edge capture. A one at position 15 or 16 must go unseen in a 14-clock frame and must be flagged in a 16-clock frame. An off-by-one in the position counter would therefore flag the wrong frames or shift the data word by one bit. For several dividers the bench counts the low time of chip select and the falling edges the converter model sees, which exposes a frame that ends early, runs an extra edge or ignores the divider. It also issues starts in the middle of a frame and inside the quiet window: a reader without the gate would open a frame at once or queue a second one.

// File: rtl/adc_rd_pkg.sv
// Package: shared constants and types of the ADC frame reader.
package adc_rd_pkg;
    localparam int OUT_W       = 12;  // width of the result word
    localparam int FRAME_LONG  = 16;  // serial clocks in a full frame
    localparam int FRAME_SHORT = 14;  // serial clocks in a shortened frame
    localparam int LEAD_ZEROS  = 2;   // zero bits ahead of the data field
    localparam int POS_W       = 5;   // width of a frame position (0..16)

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_ACTIVE = 1'b1
    } seq_state_t;
endpackage

// File: rtl/adc_half_timer.sv
// Module: adc_half_timer
// Pulses tick once every max(div_half,1) system clocks while run is high.
// Assumes: the count restarts from zero on each rise of run.
module adc_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_half,
    output logic             tick
);
    logic [DIV_W-1:0] hcnt;
    logic [DIV_W-1:0] limit;

    // Effective half period: a divider of zero behaves as one.
    always_comb limit = (div_half == '0) ? DIV_W'(1) : div_half;

    // End of the current half period.
    always_comb tick = run && (hcnt == limit - DIV_W'(1));

    // Count system clocks inside the half period; cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) hcnt <= '0;
        else if (tick)      hcnt <= '0;
        else                hcnt <= hcnt + DIV_W'(1);
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/adc_frame_seq.sv
// Module: adc_frame_seq
// Runs chip select and the serial clock for one frame, enforces the quiet gap
// and tells the capture stage when to sample and which frame position it sees.
// Assumes: tick comes from a half-period timer that runs while busy is high.
module adc_frame_seq
    import adc_rd_pkg::*;
#(
    parameter int QUIET_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               short_frame,
    input  logic               rise_sample,
    input  logic [QUIET_W-1:0] quiet_cycles,
    input  logic               tick,
    output logic               busy,
    output logic               cs_n,
    output logic               sclk,
    output logic               smp_stb,
    output logic [POS_W-1:0]   smp_pos,
    output logic               frame_clr,
    output logic               frame_done
);
    seq_state_t         state;
    logic [POS_W-1:0]   fall_cnt;
    logic [POS_W-1:0]   frame_len;
    logic [QUIET_W-1:0] qcnt;
    logic               short_q;
    logic               rise_q;
    logic               accept;

    // Frame length chosen at acceptance.
    always_comb frame_len = short_q ? POS_W'(FRAME_SHORT) : POS_W'(FRAME_LONG);

    // A start is taken only in idle with the quiet gap served.
    always_comb accept = (state == SEQ_IDLE) && start && (qcnt >= quiet_cycles);

    // Decode of the current tick into a sample strobe or the end of the frame.
    always_comb begin
        smp_stb    = 1'b0;
        frame_done = 1'b0;
        smp_pos    = fall_cnt + POS_W'(1);
        if (state == SEQ_ACTIVE && tick) begin
            if (sclk)                       smp_stb    = !rise_q;
            else if (fall_cnt == frame_len) frame_done = 1'b1;
            else                            smp_stb    = rise_q;
        end
    end

    always_comb frame_clr = accept;
    always_comb busy      = (state == SEQ_ACTIVE);

    // Frame state, pins, edge counter and quiet counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            cs_n     <= 1'b1;
            sclk     <= 1'b1;
            fall_cnt <= '0;
            qcnt     <= '0;
            short_q  <= 1'b0;
            rise_q   <= 1'b0;
        end else if (state == SEQ_IDLE) begin
            if (qcnt != '1) qcnt <= qcnt + QUIET_W'(1);
            if (accept) begin
                state    <= SEQ_ACTIVE;
                cs_n     <= 1'b0;
                fall_cnt <= '0;
                short_q  <= short_frame;
                rise_q   <= rise_sample;
            end
        end else if (tick) begin
            if (sclk) begin
                sclk     <= 1'b0;
                fall_cnt <= fall_cnt + POS_W'(1);
            end else if (frame_done) begin
                state <= SEQ_IDLE;
                cs_n  <= 1'b1;
                sclk  <= 1'b1;
                qcnt  <= '0;
            end else begin
                sclk <= 1'b1;
            end
        end
    end

    // R2
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
    // R4
    no_early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> ($past(fall_cnt) == $past(frame_len)));
    // R10
    quiet_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(qcnt) >= $past(quiet_cycles)));
    // R6
    skip_first_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && rise_q) |-> (smp_pos != POS_W'(1)));
endmodule

// File: rtl/adc_bit_capture.sv
// Module: adc_bit_capture
// Shifts the data field of a frame into a word and ORs every other captured
// position into an error flag; publishes both with a one-cycle valid.
// Assumes: done never coincides with a sample strobe.
module adc_bit_capture
    import adc_rd_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             stb,
    input  logic [POS_W-1:0] pos,
    input  logic             sdin,
    input  logic             done,
    output logic [OUT_W-1:0] result,
    output logic             result_valid,
    output logic             frame_err
);
    localparam logic [POS_W-1:0] FIRST_D = POS_W'(LEAD_ZEROS + 1);
    localparam logic [POS_W-1:0] LAST_D  = POS_W'(LEAD_ZEROS + RES_BITS);

    logic [RES_BITS-1:0] shreg;
    logic [OUT_W-1:0]    ext;
    logic                err_acc;
    logic                in_data;

    // Whether the sampled position belongs to the data field.
    always_comb in_data = (pos >= FIRST_D) && (pos <= LAST_D);

    // Right-align the data word, zero above it.
    always_comb begin
        ext = '0;
        ext[RES_BITS-1:0] = shreg;
    end

    // Collect data bits and framing faults of the running frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shreg   <= '0;
            err_acc <= 1'b0;
        end else if (stb) begin
            if (in_data) shreg   <= {shreg[RES_BITS-2:0], sdin};
            else         err_acc <= err_acc | sdin;
        end
    end

    // Publish the finished frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
            frame_err    <= 1'b0;
        end else begin
            result_valid <= done;
            if (done) begin
                result    <= ext;
                frame_err <= err_acc;
            end
        end
    end

    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    // R8
    err_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(frame_err));
endmodule

// File: rtl/adc_frame_reader.sv
// Module: adc_frame_reader
// Top of the ADC serial frame reader: half-period timer, frame sequencer and
// bit capture. Assumes RES_BITS is 12, 10 or 8 and the converter shifts data
// out on serial clock falling edges.
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int RES_BITS = 12,
    parameter int DIV_W    = 8,
    parameter int QUIET_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               short_frame,
    input  logic               rise_sample,
    input  logic [DIV_W-1:0]   div_half,
    input  logic [QUIET_W-1:0] quiet_cycles,
    input  logic               sdata_in,
    output logic               cs_n,
    output logic               sclk,
    output logic               busy,
    output logic [11:0]        result,
    output logic               result_valid,
    output logic               frame_err
);
    logic             tick;
    logic             smp_stb;
    logic [POS_W-1:0] smp_pos;
    logic             frame_clr;
    logic             frame_done;

    adc_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div_half (div_half),
        .tick     (tick)
    );

    adc_frame_seq #(.QUIET_W(QUIET_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .short_frame  (short_frame),
        .rise_sample  (rise_sample),
        .quiet_cycles (quiet_cycles),
        .tick         (tick),
        .busy         (busy),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .smp_stb      (smp_stb),
        .smp_pos      (smp_pos),
        .frame_clr    (frame_clr),
        .frame_done   (frame_done)
    );

    adc_bit_capture #(.RES_BITS(RES_BITS)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (frame_clr),
        .stb          (smp_stb),
        .pos          (smp_pos),
        .sdin         (sdata_in),
        .done         (frame_done),
        .result       (result),
        .result_valid (result_valid),
        .frame_err    (frame_err)
    );

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && sclk));
endmodule

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        short_frame = 1'b0;
    logic        rise_sample = 1'b0;
    logic [7:0]  div_half = 8'd1;
    logic [7:0]  quiet_cycles = 8'd2;
    logic        sdata_in = 1'b0;
    logic        cs_n, sclk, busy, result_valid, frame_err;
    logic [11:0] result;

    int checks = 0;
    int failures = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    adc_frame_reader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .short_frame(short_frame),
        .rise_sample(rise_sample), .div_half(div_half), .quiet_cycles(quiet_cycles),
        .sdata_in(sdata_in), .cs_n(cs_n), .sclk(sclk), .busy(busy),
        .result(result), .result_valid(result_valid), .frame_err(frame_err)
    );

    // Converter model: position 1 on the select fall, next position per falling edge.
    logic [16:1] fbits = '0;
    int idx = 0;
    int fall_seen = 0;
    always @(negedge cs_n, negedge sclk) begin
        if (sclk) idx = 1;
        else begin
            idx = idx + 1;
            fall_seen = fall_seen + 1;
        end
        sdata_in <= #1 (idx >= 1 && idx <= 16) ? fbits[idx] : 1'b0;
    end

    function automatic logic [16:1] build(input logic [11:0] v, input int p);
        logic [16:1] b = '0;
        for (int i = 0; i < 12; i++) b[14-i] = v[i];
        if (p != 0) b[p] = 1'b1;
        return b;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // {value, short, rise, divider, planted one position, expected error}
    localparam logic [31:0] VEC [10] = '{
        {12'hA5C, 1'b0, 1'b0, 4'd1, 5'd0,  1'b0, 8'd0},
        {12'h3F0, 1'b0, 1'b1, 4'd2, 5'd0,  1'b0, 8'd0},
        {12'hFFF, 1'b1, 1'b0, 4'd1, 5'd0,  1'b0, 8'd0},
        {12'h001, 1'b1, 1'b1, 4'd3, 5'd0,  1'b0, 8'd0},
        {12'h800, 1'b0, 1'b0, 4'd2, 5'd1,  1'b1, 8'd0},
        {12'h555, 1'b0, 1'b1, 4'd1, 5'd1,  1'b0, 8'd0},
        {12'h0AA, 1'b0, 1'b0, 4'd0, 5'd16, 1'b1, 8'd0},
        {12'h123, 1'b1, 1'b0, 4'd2, 5'd15, 1'b0, 8'd0},
        {12'h7FE, 1'b0, 1'b1, 4'd1, 5'd2,  1'b1, 8'd0},
        {12'h000, 1'b0, 1'b1, 4'd1, 5'd15, 1'b1, 8'd0}
    };

    task automatic run_frame(input logic [11:0] v, input bit sh, input bit rs,
                             input int dv, input int p, input bit exp_err, input bit poke);
        int n = sh ? 14 : 16;
        int d = (dv == 0) ? 1 : dv;
        int f0;
        int lowcnt = 0;
        int guard = 0;
        fbits = build(v, p);
        short_frame = sh;
        rise_sample = rs;
        div_half = 8'(dv);
        f0 = fall_seen;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!result_valid && guard < 2000) begin
            if (!cs_n) lowcnt++;
            if (poke && lowcnt == 5) start = 1'b1;
            else start = 1'b0;
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        check(result_valid, "R9 valid seen", result_valid, 1);
        check(result == v, "R5/R6/R7 result", result, v);
        check(frame_err == exp_err, "R8 frame_err", frame_err, exp_err);
        check(lowcnt == 2 * n * d, "R3 select low cycles", lowcnt, 2 * n * d);
        check(fall_seen - f0 == n, "R4 falling edges", fall_seen - f0, n);
        check(cs_n && sclk, "R2 pins idle at valid", {cs_n, sclk}, 3);
        @(negedge clk);
        check(!result_valid, "R9 valid one cycle", result_valid, 0);
        check(cs_n, "R10 no queued start", cs_n, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
        check(sclk == 1'b1, "R1 sclk in reset", sclk, 1);
        check(!result_valid && !busy, "R1 valid/busy in reset", {result_valid, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n && !busy, "R1 idle after reset", {cs_n, busy}, 2);
        repeat (4) @(negedge clk);

        // Table of frames: R5 R6 R7 R8 R3 R4
        for (int i = 0; i < 10; i++) begin
            logic [31:0] e = VEC[i];
            run_frame(e[31:20], e[19], e[18], int'(e[17:14]), int'(e[13:9]), e[8], 1'b0);
            repeat (4) @(negedge clk);
        end

        // R10 start during a frame is ignored
        run_frame(12'h9C3, 1'b0, 1'b0, 2, 0, 1'b0, 1'b1);

        // R10 quiet window blocks an early start
        quiet_cycles = 8'd30;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (3) @(negedge clk);
        check(cs_n && !busy, "R10 start inside quiet gap", {cs_n, busy}, 2);
        repeat (40) @(negedge clk);
        run_frame(12'h00F, 1'b1, 1'b1, 1, 0, 1'b0, 1'b0);

        // R2 select low before the first serial clock fall
        quiet_cycles = 8'd0;
        repeat (2) @(negedge clk);
        div_half = 8'd3;
        short_frame = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(!cs_n && sclk, "R2 select low, clock still high", {cs_n, sclk}, 1);
        repeat (3) @(negedge clk);
        check(!cs_n && !sclk, "R2 first fall after half period", {cs_n, sclk}, 0);
        repeat (200) @(negedge clk);

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule